// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

A purely combinational arithmetic and logic unit for a small accumulator-style processor. It takes a register operand, a memory operand, the incoming carry and overflow flags, the decimal-mode flag and a 4-bit operation select. It returns a result, the new carry and overflow values, zero and negative indications, a strobe telling the surrounding datapath whether the result should be written back, and an unsupported-operation indication.

The operation set covers binary add and subtract through carry, the three bitwise logic operations, shifts and rotates of the memory operand, increment and decrement of the memory operand, compare and bit test. Compare and bit test touch only the flags. Decimal-mode arithmetic is not implemented. An add or subtract issued while the decimal flag is set is refused through the unsupported output, and no result is written.

The datapath width and the adder structure (a behavioural adder or an explicit ripple chain) are parameters. The compare path shares the main adder with subtract.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 (add) returns (A + M + Cin) mod 256, carry_o is set when the sum exceeds 255, ovf_o is set when the signed sum leaves -128..127, and wr_o is 1.
- R2: Operation code 1 (subtract) returns (A - M - (1 - Cin)) mod 256, carry_o is 1 exactly when no borrow occurs (the true difference is not negative), ovf_o is set when the signed difference leaves -128..127, and wr_o is 1.
- R3: Operation code 11 (compare) evaluates A - M with the carry forced to 1. carry_o = (A >= M), zero and negative follow the difference, ovf_o equals ovf_i, and wr_o is 0.
- R4: Operation codes 2, 3 and 4 return A AND M, A OR M and A XOR M, with wr_o = 1 and carry_o and ovf_o equal to their inputs.
- R5: Operation code 5 shifts M left, with bit 7 going to carry_o and 0 entering at bit 0. Code 6 shifts M right, with bit 0 going to carry_o and 0 entering at bit 7. Both set wr_o, and ovf_o equals ovf_i.
- R6: Operation code 7 rotates M left with carry_i entering bit 0 and bit 7 leaving to carry_o. Code 8 rotates M right with carry_i entering bit 7 and bit 0 leaving to carry_o. Both set wr_o, and ovf_o equals ovf_i.
- R7: Operation code 12 (bit test) gives zero_o = ((A AND M) == 0), neg_o = M bit 7 and ovf_o = M bit 6, with carry_o equal to carry_i and wr_o = 0.
- R8: Operation codes 9 and 10 return (M + 1) mod 256 and (M - 1) mod 256 with wr_o = 1, and carry_o and ovf_o equal their inputs.
- R9: For every operation except bit test, zero_o is 1 exactly when the produced value is 0, and neg_o equals its bit 7.
- R10: With decimal_i = 1, add and subtract give unsup_o = 1 and wr_o = 0, with carry_o and ovf_o unchanged. For every other operation, decimal_i has no effect, and unsup_o is 0 whenever decimal_i is 0.
- R11: Operation codes 13 to 15 give wr_o = 0 and unsup_o = 0, with carry_o and ovf_o equal to their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Register operand (accumulator or index register) |
| m_i | input | 8 | Memory or immediate operand |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| decimal_i | input | 1 | Decimal-mode flag |
| op_i | input | 4 | Operation select (codes in R1 to R11) |
| res_o | output | 8 | Result value |
| carry_o | output | 1 | New carry flag |
| ovf_o | output | 1 | New overflow flag |
| zero_o | output | 1 | Zero indication |
| neg_o | output | 1 | Negative indication |
| wr_o | output | 1 | Result should be written back |
| unsup_o | output | 1 | Operation refused (decimal arithmetic) |

## Verification
Two functions can act in the same cycle: the decimal refusal and the binary adder. Both respond to an add or subtract, and the refusal must win, leaving the flags untouched. The sweep drives every operation code with decimal_i both low and high, over every register operand value against a spread of memory operand values, so that the adder produces carries and overflows while the refusal is active. Each vector is judged against an integer model that lets the refusal override the arithmetic only for codes 0 and 1. Dedicated corners cover signed overflow boundaries, wrap of increment and decrement, equal-value compare, and bit test with M bits 7 and 6 set.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int OP_W = 4;
   typedef enum logic [OP_W-1:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_XOR = 4'd4,
      OP_SHL = 4'd5,
      OP_SHR = 4'd6,
      OP_ROL = 4'd7,
      OP_ROR = 4'd8,
      OP_INC = 4'd9,
      OP_DEC = 4'd10,
      OP_CMP = 4'd11,
      OP_BIT = 4'd12
   } alu_op_e;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int WIDTH      = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);
   if (RIPPLE_ADD) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum_o[i]    = x_i[i] ^ y_i[i] ^ chain[i];
         assign chain[i+1]  = (x_i[i] & y_i[i]) | (chain[i] & (x_i[i] ^ y_i[i]));
      end
      assign cout_o = chain[WIDTH];
      assign ovf_o  = chain[WIDTH] ^ chain[WIDTH-1];
   end else begin : g_behav
      logic [WIDTH:0] full;
      assign full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
      assign sum_o  = full[WIDTH-1:0];
      assign cout_o = full[WIDTH];
      assign ovf_o  = (x_i[WIDTH-1] == y_i[WIDTH-1]) && (full[WIDTH-1] != x_i[WIDTH-1]);
   end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] m_i,
   output logic [WIDTH-1:0] res_o
);
   always_comb begin
      unique case (op_i)
         OP_OR:   res_o = a_i | m_i;
         OP_XOR:  res_o = a_i ^ m_i;
         default: res_o = a_i & m_i;
      endcase
   end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] m_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   logic fill;
   logic left;

   always_comb begin
      left = (op_i == OP_SHL) || (op_i == OP_ROL);
      fill = ((op_i == OP_ROL) || (op_i == OP_ROR)) ? cin_i : 1'b0;
      if (left) begin
         res_o  = {m_i[WIDTH-2:0], fill};
         cout_o = m_i[WIDTH-1];
      end else begin
         res_o  = {fill, m_i[WIDTH-1:1]};
         cout_o = m_i[0];
      end
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic             [WIDTH-1:0] a_i,
   input  logic             [WIDTH-1:0] m_i,
   input  logic                         carry_i,
   input  logic                         ovf_i,
   input  logic                         decimal_i,
   input  logic             [OP_W-1:0]  op_i,
   output logic             [WIDTH-1:0] res_o,
   output logic                         carry_o,
   output logic                         ovf_o,
   output logic                         zero_o,
   output logic                         neg_o,
   output logic                         wr_o,
   output logic                         unsup_o
);
   localparam int MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   if (WIDTH < 3) begin : g_width_bad
      $error("acc_alu: WIDTH must be at least 3");
   end

   alu_op_e          op;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH-1:0] add_sum;
   logic             add_c;
   logic             add_v;
   logic [WIDTH-1:0] log_r;
   logic [WIDTH-1:0] sh_r;
   logic             sh_c;
   logic             subtracting;

   assign op          = alu_op_e'(op_i);
   assign subtracting = (op == OP_SUB) || (op == OP_CMP);
   assign add_y       = subtracting ? ~m_i : m_i;
   assign add_cin     = (op == OP_CMP) ? 1'b1 : carry_i;

   acc_alu_adder #(.WIDTH(WIDTH), .RIPPLE_ADD(RIPPLE_ADD)) u_adder (
      .x_i    (a_i),
      .y_i    (add_y),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .cout_o (add_c),
      .ovf_o  (add_v)
   );

   acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op_i  (op),
      .a_i   (a_i),
      .m_i   (m_i),
      .res_o (log_r)
   );

   acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
      .op_i   (op),
      .m_i    (m_i),
      .cin_i  (carry_i),
      .res_o  (sh_r),
      .cout_o (sh_c)
   );

   always_comb begin
      res_o   = '0;
      carry_o = carry_i;
      ovf_o   = ovf_i;
      wr_o    = 1'b0;
      unsup_o = 1'b0;
      case (op)
         OP_ADD, OP_SUB: begin
            if (decimal_i) begin
               unsup_o = 1'b1;
            end else begin
               res_o   = add_sum;
               carry_o = add_c;
               ovf_o   = add_v;
               wr_o    = 1'b1;
            end
         end
         OP_CMP: begin
            res_o   = add_sum;
            carry_o = add_c;
         end
         OP_AND, OP_OR, OP_XOR: begin
            res_o = log_r;
            wr_o  = 1'b1;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            res_o   = sh_r;
            carry_o = sh_c;
            wr_o    = 1'b1;
         end
         OP_INC: begin
            res_o = m_i + ONE;
            wr_o  = 1'b1;
         end
         OP_DEC: begin
            res_o = m_i - ONE;
            wr_o  = 1'b1;
         end
         OP_BIT: begin
            res_o = log_r;
            ovf_o = m_i[MSB-1];
         end
         default: ;
      endcase
      zero_o = (res_o == '0);
      neg_o  = (op == OP_BIT) ? m_i[MSB] : res_o[MSB];
   end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] m_i,
   input logic             carry_i,
   input logic             ovf_i,
   input logic             decimal_i,
   input logic [OP_W-1:0]  op_i,
   input logic [WIDTH-1:0] res_o,
   input logic             carry_o,
   input logic             ovf_o,
   input logic             zero_o,
   input logic             neg_o,
   input logic             wr_o,
   input logic             unsup_o
);
   always_comb begin
      if (op_i == OP_CMP) begin
         // R3
         cmp_flags_only_chk: assert (!wr_o && ovf_o == ovf_i && carry_o == (a_i >= m_i));
      end
      if (op_i == OP_BIT) begin
         // R7
         bit_test_chk: assert (!wr_o && neg_o == m_i[WIDTH-1] && ovf_o == m_i[WIDTH-2]
                               && carry_o == carry_i && zero_o == ((a_i & m_i) == '0));
      end
      if (op_i == OP_INC || op_i == OP_DEC) begin
         // R8
         incdec_keep_chk: assert (wr_o && carry_o == carry_i && ovf_o == ovf_i);
      end
      if (decimal_i && (op_i == OP_ADD || op_i == OP_SUB)) begin
         // R10
         decimal_refuse_chk: assert (unsup_o && !wr_o && carry_o == carry_i && ovf_o == ovf_i);
      end
      // R10
      unsup_source_chk: assert (!unsup_o || decimal_i);
      if (wr_o) begin
         // R9
         zero_neg_chk: assert (zero_o == (res_o == '0) && neg_o == res_o[WIDTH-1]);
      end
      if (op_i > OP_BIT) begin
         // R11
         unused_code_chk: assert (!wr_o && !unsup_o && carry_o == carry_i && ovf_o == ovf_i);
      end
   end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .a_i(a_i), .m_i(m_i), .carry_i(carry_i), .ovf_i(ovf_i), .decimal_i(decimal_i),
   .op_i(op_i), .res_o(res_o), .carry_o(carry_o), .ovf_o(ovf_o), .zero_o(zero_o),
   .neg_o(neg_o), .wr_o(wr_o), .unsup_o(unsup_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
   logic       clk = 1'b0;
   logic [7:0] a, m, res;
   logic       ci, vi, dec;
   logic [3:0] op;
   logic       co, vo, z, n, wr, un;
   int         total = 0;
   int         bad = 0;
   bit         done = 0;

   always #5 clk = ~clk;

   acc_alu u_dut (
      .a_i(a), .m_i(m), .carry_i(ci), .ovf_i(vi), .decimal_i(dec), .op_i(op),
      .res_o(res), .carry_o(co), .ovf_o(vo), .zero_o(z), .neg_o(n), .wr_o(wr), .unsup_o(un)
   );

   function automatic string tag_of(int o, int d);
      if (d != 0 && o <= 1) return "R10";
      case (o)
         0: return "R1";  1: return "R2";  2, 3, 4: return "R4";
         5, 6: return "R5"; 7, 8: return "R6"; 9, 10: return "R8";
         11: return "R3"; 12: return "R7";
         default: return "R11";
      endcase
   endfunction

   function automatic int sgn(int x);
      return (x > 127) ? x - 256 : x;
   endfunction

   task automatic apply(input int o, input int av, input int mv, input int c, input int v, input int d);
      int er, ec, ev, ew, eu, ez, en, s, sv;
      bit ok;
      op = 4'(o); a = 8'(av); m = 8'(mv); ci = c[0]; vi = v[0]; dec = d[0];
      #1;
      er = 0; ec = c; ev = v; ew = 0; eu = 0;
      case (o)
         0: if (d != 0) eu = 1; else begin
               s = av + mv + c; er = s % 256; ec = (s > 255); sv = sgn(av) + sgn(mv) + c;
               ev = (sv > 127 || sv < -128); ew = 1; end
         1: if (d != 0) eu = 1; else begin
               s = av - mv - (1 - c); ec = (s >= 0); er = (s + 512) % 256;
               sv = sgn(av) - sgn(mv) - (1 - c); ev = (sv > 127 || sv < -128); ew = 1; end
         2: begin er = av & mv; ew = 1; end
         3: begin er = av | mv; ew = 1; end
         4: begin er = av ^ mv; ew = 1; end
         5: begin er = (mv * 2) % 256; ec = mv / 128; ew = 1; end
         6: begin er = mv / 2; ec = mv % 2; ew = 1; end
         7: begin er = (mv * 2) % 256 + c; ec = mv / 128; ew = 1; end
         8: begin er = mv / 2 + c * 128; ec = mv % 2; ew = 1; end
         9: begin er = (mv + 1) % 256; ew = 1; end
         10: begin er = (mv + 255) % 256; ew = 1; end
         11: begin s = av - mv; ec = (s >= 0); er = (s + 256) % 256; end
         12: begin er = av & mv; ev = (mv / 64) % 2; end
         default: ;
      endcase
      ez = (er == 0); en = (o == 12) ? mv / 128 : er / 128;
      ok = (int'(wr) == ew) && (int'(un) == eu) && (int'(co) == ec) && (int'(vo) == ev);
      if (ew != 0 && int'(res) != er) ok = 0;
      if (eu == 0 && o <= 12 && (int'(z) != ez || int'(n) != en)) ok = 0;
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s op=%0d a=%02h m=%02h c=%0d v=%0d d=%0d: got res=%02h c=%0b v=%0b z=%0b n=%0b wr=%0b un=%0b exp res=%02h c=%0d v=%0d z=%0d n=%0d wr=%0d un=%0d",
                  tag_of(o, d), o, av, mv, c, v, d, res, co, vo, z, n, wr, un, er, ec, ev, ez, en, ew, eu);
      end
   endtask

   initial begin
      // idle state: all inputs zero is an add of 0+0, R1 and R9
      apply(0, 0, 0, 0, 0, 0);
      // R1 signed overflow corners
      apply(0, 8'h7F, 8'h01, 0, 0, 0);
      apply(0, 8'h80, 8'hFF, 0, 0, 0);
      apply(0, 8'hFF, 8'h00, 1, 0, 0);
      // R2 borrow and overflow corners
      apply(1, 8'h80, 8'h01, 1, 0, 0);
      apply(1, 8'h00, 8'h00, 0, 0, 0);
      // R3 equal compare and R7 high-bit bit test
      apply(11, 8'h42, 8'h42, 0, 1, 0);
      apply(12, 8'h3F, 8'hC0, 1, 0, 0);
      // R8 wrap corners
      apply(9, 0, 8'hFF, 1, 1, 0);
      apply(10, 0, 8'h00, 0, 0, 0);
      // R6 carry rotated in
      apply(8, 0, 8'h01, 1, 0, 0);
      // R10 decimal refusal with carrying operands
      apply(0, 8'hFF, 8'hFF, 1, 0, 1);
      // R4 R5 R9 R11 full sweep, decimal both ways
      for (int o = 0; o < 16; o++)
         for (int d = 0; d < 2; d++)
            for (int c = 0; c < 2; c++)
               for (int av = 0; av < 256; av++)
                  for (int k = 0; k < 16; k++)
                     apply(o, av, (k * 17 + av) % 256, c, (av ^ k) & 1, d);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule